// File: doc/BRIEF.md
# Weighted Hysteretic Threshold Gate

This block models one threshold element from a dual-rail, null-separated logic style. Each input carries an integer weight. When the weights of the asserted inputs add up to the threshold or more, the output goes high. The output goes low only once every input has returned to zero. For any other input pattern the output keeps the value it already has. This hysteresis is what lets a downstream stage treat a high output as "result complete" and a low output as "fully reset".

The hold behaviour is stored in an explicit state bit that is sampled on a clock. The gate is sized by three parameters: the input count, the threshold and a packed vector of per-input weights. Weights default to 1. Elaboration rejects an input count outside 1 to 8, a threshold below 1 and a threshold above the total weight.

Top module: `th_gate`

## Requirements
- R1: While rst_ni is low, out_o is 0, and it is still 0 on the first clock edge after reset is released.
- R2: If every bit of in_i is 0 at a rising clock edge, out_o is 0 after that edge, whatever its value was before.
- R3: If the sum of the weights of the asserted bits of in_i is at least THRESH at a rising clock edge, out_o is 1 after that edge.
- R4: If in_i is nonzero and its weighted sum is below THRESH, out_o keeps the value it had before the edge.
- R5: Bit i of in_i counts with the weight held in WEIGHTS[i*WEIGHT_W +: WEIGHT_W]. For THRESH=2 with weights (bit0=2, bit1=1, bit2=1), bit 0 alone sets the output, and bits 1 and 2 together set it.
- R6: In that same 2-of-3 configuration, bit 1 alone or bit 2 alone leaves out_o unchanged, whether it was 0 or 1.
- R7: out_o is registered. A change on in_i has no effect on out_o until the next rising edge of clk_i.
- R8: With default unit weights and THRESH equal to the input count (for example 4 of 4), the output sets only when all inputs are 1. Any three of four only holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Sampling clock for the state bit |
| rst_ni | input | 1 | Active-low asynchronous reset; clears the state bit |
| in_i | input | N_IN | Gate inputs, each asserted line counted with its weight |
| out_o | output | 1 | Hysteretic gate output |

## Verification
The only state is one bit, and it is visible directly on out_o. A wrong set, clear or hold decision therefore shows as a wrong output value on the very next clock edge. An error in one weight or in the threshold comparison only shows for input patterns whose weighted sum lies exactly at or just below the threshold. For that reason every input vector is applied from both a set state and a cleared state, across three configurations: weighted 2-of-3, 2-of-2 and 4-of-4.

// File: rtl/th_pkg.sv
package th_pkg;
  localparam int unsigned MAX_INPUTS = 8;

  typedef enum logic [1:0] {
    ACT_HOLD  = 2'd0,
    ACT_SET   = 2'd1,
    ACT_CLEAR = 2'd2
  } th_act_e;
endpackage

// File: rtl/th_weight_sum.sv
module th_weight_sum #(
  parameter int unsigned N_IN     = 3,
  parameter int unsigned WEIGHT_W = 4,
  parameter int unsigned SUM_W    = 6,
  parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS = '0
) (
  input  logic [N_IN-1:0]  in_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] part [N_IN+1];

  assign part[0] = '0;

  // chained partial sums, one adder per input
  for (genvar i = 0; i < N_IN; i++) begin : g_acc
    logic [SUM_W-1:0] w_ext;
    assign w_ext       = SUM_W'(WEIGHTS[i*WEIGHT_W +: WEIGHT_W]);
    assign part[i+1]   = part[i] + (in_i[i] ? w_ext : '0);
  end

  assign sum_o = part[N_IN];
endmodule

// File: rtl/th_decide.sv
module th_decide #(
  parameter int unsigned N_IN   = 3,
  parameter int unsigned SUM_W  = 6,
  parameter int unsigned THRESH = 2
) (
  input  logic [N_IN-1:0]  in_i,
  input  logic [SUM_W-1:0] sum_i,
  output th_pkg::th_act_e  act_o
);
  import th_pkg::*;

  // clear needs every input low; set needs sum at threshold
  always_comb begin
    if (in_i == '0)                   act_o = ACT_CLEAR;
    else if (sum_i >= SUM_W'(THRESH)) act_o = ACT_SET;
    else                              act_o = ACT_HOLD;
  end
endmodule

// File: rtl/th_hold_reg.sv
module th_hold_reg (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  th_pkg::th_act_e act_i,
  output logic            q_o
);
  import th_pkg::*;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_o <= 1'b0;
    end else begin
      unique case (act_i)
        ACT_SET:   q_o <= 1'b1;
        ACT_CLEAR: q_o <= 1'b0;
        default:   q_o <= q_o;
      endcase
    end
  end
endmodule

// File: rtl/th_gate.sv
module th_gate #(
  parameter int unsigned N_IN     = 3,
  parameter int unsigned WEIGHT_W = 4,
  parameter int unsigned THRESH   = 2,
  parameter logic [N_IN*WEIGHT_W-1:0] WEIGHTS =
    {N_IN{{(WEIGHT_W-1){1'b0}}, 1'b1}}
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_IN-1:0] in_i,
  output logic            out_o
);
  import th_pkg::*;

  localparam int unsigned SUM_W = WEIGHT_W + $clog2(N_IN + 1);

  function automatic int unsigned total_weight();
    int unsigned t = 0;
    for (int i = 0; i < int'(N_IN); i++) t += int'(WEIGHTS[i*WEIGHT_W +: WEIGHT_W]);
    return t;
  endfunction

  localparam int unsigned TOTAL_W = total_weight();

  if (N_IN < 1 || N_IN > MAX_INPUTS) begin : g_bad_n
    $error("th_gate: N_IN out of range");
  end
  if (THRESH < 1 || THRESH > TOTAL_W) begin : g_bad_m
    $error("th_gate: THRESH must lie in 1..total weight");
  end

  logic [SUM_W-1:0] sum;
  th_act_e          act;

  th_weight_sum #(
    .N_IN(N_IN), .WEIGHT_W(WEIGHT_W), .SUM_W(SUM_W), .WEIGHTS(WEIGHTS)
  ) u_sum (
    .in_i (in_i),
    .sum_o(sum)
  );

  th_decide #(
    .N_IN(N_IN), .SUM_W(SUM_W), .THRESH(THRESH)
  ) u_dec (
    .in_i (in_i),
    .sum_i(sum),
    .act_o(act)
  );

  th_hold_reg u_reg (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .act_i (act),
    .q_o   (out_o)
  );

  // R1: output still low on first edge out of reset
  a_r1_reset_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> !out_o);

  // R2: all-zero inputs clear the output
  a_r2_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i == '0) |=> !out_o);

  // R3: weighted sum at threshold sets the output
  a_r3_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sum >= SUM_W'(THRESH)) |=> out_o);

  // R4: partial inputs hold the output
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_i != '0 && sum < SUM_W'(THRESH)) |=> $stable(out_o));
endmodule

// File: tb/sim_th_gate.sv
`timescale 1ns/1ps
module sim_th_gate;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] stim = '0;
  logic       o0, o1, o2;
  logic       e0, e1, e2;
  int         n_chk = 0;
  int         n_err = 0;
  bit         done = 0;

  always #2.5 clk_i = ~clk_i;

  // 2-of-3, bit0 weight 2
  th_gate #(.N_IN(3), .WEIGHT_W(4), .THRESH(2), .WEIGHTS({4'd1, 4'd1, 4'd2}))
    u0 (.clk_i(clk_i), .rst_ni(rst_ni), .in_i(stim[2:0]), .out_o(o0));
  // 2-of-2, default weights
  th_gate #(.N_IN(2), .THRESH(2))
    u1 (.clk_i(clk_i), .rst_ni(rst_ni), .in_i(stim[1:0]), .out_o(o1));
  // 4-of-4, default weights
  th_gate #(.N_IN(4), .THRESH(4))
    u2 (.clk_i(clk_i), .rst_ni(rst_ni), .in_i(stim), .out_o(o2));

  function automatic logic nxt(int s, int m, bit zero, logic q);
    if (zero) return 1'b0;
    if (s >= m) return 1'b1;
    return q;
  endfunction

  task automatic chk(string req, string who, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: got %0b expected %0b (stim=%b)", req, who, act, exp, stim);
    end
  endtask

  function automatic string tag_u0(logic [2:0] v, int s);
    if (v == 3'b000) return "R2";
    if (v == 3'b001 || v == 3'b110) return "R5";
    if (v == 3'b010 || v == 3'b100) return "R6";
    return (s >= 2) ? "R3" : "R4";
  endfunction

  // drive at negedge, check no early change, check after next edge
  task automatic step(logic [3:0] v);
    int s0, s1, s2;
    string t1, t2;
    @(negedge clk_i);
    stim = v;
    #1;
    chk("R7", "u0", o0, e0);
    chk("R7", "u2", o2, e2);
    s0 = 2*v[0] + v[1] + v[2];
    s1 = v[0] + v[1];
    s2 = v[0] + v[1] + v[2] + v[3];
    e0 = nxt(s0, 2, v[2:0] == 0, e0);
    e1 = nxt(s1, 2, v[1:0] == 0, e1);
    e2 = nxt(s2, 4, v == 0, e2);
    t1 = (v[1:0] == 0) ? "R2" : (s1 >= 2 ? "R3" : "R4");
    t2 = (v == 0) ? "R2" : (s2 >= 3 ? "R8" : "R4");
    @(posedge clk_i);
    @(negedge clk_i);
    chk(tag_u0(v[2:0], s0), "u0", o0, e0);
    chk(t1, "u1", o1, e1);
    chk(t2, "u2", o2, e2);
  endtask

  initial begin
    #100_0000;
    if (!done) begin
      n_err++;
      n_chk++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    e0 = 0; e1 = 0; e2 = 0;
    stim = 4'hF;
    repeat (3) @(negedge clk_i);
    chk("R1", "u0", o0, 1'b0);
    chk("R1", "u1", o1, 1'b0);
    chk("R1", "u2", o2, 1'b0);
    stim = 4'h0;
    rst_ni = 1'b1;
    @(posedge clk_i);
    @(negedge clk_i);
    chk("R1", "u0", o0, 1'b0);
    chk("R1", "u2", o2, 1'b0);
    // every vector from cleared and from set state
    for (int s = 0; s < 2; s++) begin
      for (int v = 0; v < 16; v++) begin
        step(s ? 4'hF : 4'h0);
        step(4'(v));
      end
    end
    // random walks exercising partial-to-partial transitions
    for (int k = 0; k < 600; k++) step(4'($urandom_range(0, 15)));
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule